// File: doc/BRIEF.md
# Two-Tone Discrimination Fitness Scorer

This block grades a candidate circuit whose job is to separate a low-frequency tone from a high-frequency one. It drives a tone select line to the stimulus source, watches the one-bit response of the candidate on a sampling strobe, and counts the strobes where the response is one. Counting runs over a series of equal observation windows that alternate between the two tones.

When the last window closes, the block takes the absolute difference of the two per-tone sums. It scales that difference to a 12-bit fraction of the largest possible difference and presents it on the fitness output, marked by a one-cycle done pulse. A search engine starts an evaluation, waits for done, reads the score and then reconfigures the candidate for the next one. At the real window length of 200,000 ticks of a 1 MHz strobe, with five windows per tone, one evaluation lasts about 2 s. Simulation shrinks the window through a parameter.

Top module: `tone_fitness_eval`

## Requirements
- R1: After reset, busy_o, done_o, tone_sel_o and fitness_o are all 0.
- R2: A start_i pulse seen while busy_o is low makes busy_o high in the next cycle, and the run begins with tone_sel_o at 0.
- R3: A run has 2*REPS windows, each closed by WIN_TICKS strobes. tone_sel_o is 0 (low tone) in even-numbered windows and 1 (high tone) in odd-numbered windows, starting from window 0. tone_sel_o changes only on the strobe that closes a window.
- R4: Only cycles with strobe_i high during a run count. Each such cycle with sample_i at 1 adds one to the sum of the tone currently selected. sample_i is ignored in cycles without a strobe. The sums saturate rather than wrap.
- R5: The fitness is floor(|sum_low - sum_high| * 2^FIT_W / (REPS*WIN_TICKS)), clamped to 2^FIT_W-1.
- R6: done_o pulses high for exactly one cycle, FIT_W+2 cycles after the clock edge that takes the final strobe. busy_o falls in the same cycle that done_o rises.
- R7: A start_i pulse that arrives while busy_o is high has no effect on the run in progress.
- R8: fitness_o changes only together with a done_o pulse and holds its value between pulses.
- R9: Both sums clear on an accepted start, so each result depends only on its own run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an evaluation (ignored while busy) |
| tone_sel_o | output | 1 | Stimulus select: 0 low tone, 1 high tone |
| sample_i | input | 1 | Response bit of the candidate circuit |
| strobe_i | input | 1 | Sampling tick qualifier |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | One-cycle pulse when fitness_o is updated |
| fitness_o | output | FIT_W | Scaled fitness score |

## Verification
Outputs are due as follows. busy_o and tone_sel_o respond one cycle after the edge that takes a start or a window-closing strobe. Each sample lands in its sum on the edge where its strobe is taken. The score and done_o appear FIT_W+2 edges after the final strobe: one edge to load the divider and FIT_W+1 edges to divide. The bench steps a behavioural model once per edge with the same inputs it drives, then compares every output at the following falling edge, so each check samples exactly the cycle in which the result is due. Hand-computed scores at done cover the clamp, a zero difference, both signs of the difference, samples given off-strobe, and starts given mid-run.

// File: rtl/tfe_pkg.sv
package tfe_pkg;
  typedef enum logic {TONE_LO = 1'b0, TONE_HI = 1'b1} tone_e;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tfe_window_seq.sv
module tfe_window_seq import tfe_pkg::*; #(
  parameter int unsigned WIN_TICKS = 200000,
  parameter int unsigned REPS      = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic strobe_i,
  output logic run_o,
  output tone_e tone_o,
  output logic fin_o
);
  localparam int unsigned NWIN   = 2 * REPS;
  localparam int unsigned TICK_W = bits_for(WIN_TICKS);
  localparam int unsigned WIN_W  = bits_for(NWIN);

  logic [TICK_W-1:0] tick_q;
  logic [WIN_W-1:0]  win_q;
  logic              run_q, fin_q;
  logic              last_tick;

  assign last_tick = (tick_q == TICK_W'(WIN_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      win_q  <= '0;
      run_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go_i) begin
        tick_q <= '0;
        win_q  <= '0;
        run_q  <= 1'b1;
      end else if (run_q && strobe_i) begin
        if (last_tick) begin
          tick_q <= '0;
          if (win_q == WIN_W'(NWIN - 1)) begin
            run_q <= 1'b0;
            fin_q <= 1'b1;
          end else begin
            win_q <= win_q + 1'b1;
          end
        end else begin
          tick_q <= tick_q + 1'b1;
        end
      end
    end
  end

  // even windows low tone, odd windows high tone
  assign tone_o = tone_e'(win_q[0]);
  assign run_o  = run_q;
  assign fin_o  = fin_q;

  AST_TONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !strobe_i && !go_i) |=> $stable(tone_o)); // R3
  AST_FIN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |=> !fin_q); // R6
endmodule

// File: rtl/tfe_ones_accum.sv
module tfe_ones_accum import tfe_pkg::*; #(
  parameter int unsigned SUM_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             sample_i,
  input  tone_e            tone_i,
  output logic [SUM_W-1:0] lo_o,
  output logic [SUM_W-1:0] hi_o
);
  logic [SUM_W-1:0] cnt_q [2];

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic hit;
    assign hit = en_i && sample_i && (tone_i == tone_e'(ch)) && (cnt_q[ch] != '1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q[ch] <= '0;
      else if (clr_i)   cnt_q[ch] <= '0;
      else if (hit)     cnt_q[ch] <= cnt_q[ch] + 1'b1;
    end

    AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (cnt_q[ch] >= $past(cnt_q[ch]))); // R4
  end

  assign lo_o = cnt_q[0];
  assign hi_o = cnt_q[1];
endmodule

// File: rtl/tfe_fit_div.sv
module tfe_fit_div import tfe_pkg::*; #(
  parameter int unsigned SUM_W = 20,
  parameter int unsigned FIT_W = 12,
  parameter int unsigned TOTAL = 1000000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [SUM_W-1:0] a_i,
  input  logic [SUM_W-1:0] b_i,
  output logic [FIT_W-1:0] fit_o,
  output logic             done_o,
  output logic             busy_o
);
  localparam int unsigned QB  = FIT_W + 1;
  localparam int unsigned N_W = bits_for(QB + 1);
  localparam int unsigned R_W = SUM_W + 1;
  localparam logic [R_W-1:0] DEN = R_W'(TOTAL);

  logic [R_W-1:0] rem_q, rem_sub;
  logic [QB-1:0]  quo_q, quo_nx;
  logic [N_W-1:0] n_q;
  logic           ge;
  logic [FIT_W-1:0] fit_q;
  logic           done_q;

  always_comb begin
    ge      = (rem_q >= DEN);
    rem_sub = ge ? (rem_q - DEN) : rem_q;
    quo_nx  = {quo_q[QB-2:0], ge};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      n_q    <= '0;
      fit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        rem_q <= (a_i > b_i) ? R_W'(a_i - b_i) : R_W'(b_i - a_i);
        quo_q <= '0;
        n_q   <= N_W'(QB);
      end else if (n_q != '0) begin
        rem_q <= rem_sub << 1;
        quo_q <= quo_nx;
        n_q   <= n_q - 1'b1;
        if (n_q == N_W'(1)) begin
          done_q <= 1'b1;
          fit_q  <= quo_nx[QB-1] ? '1 : quo_nx[FIT_W-1:0];
        end
      end
    end
  end

  assign fit_o  = fit_q;
  assign done_o = done_q;
  assign busy_o = (n_q != '0);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R6
  AST_FIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (done_q || $stable(fit_q))); // R8
endmodule

// File: rtl/tone_fitness_eval.sv
module tone_fitness_eval import tfe_pkg::*; #(
  parameter int unsigned WIN_TICKS = 200000,
  parameter int unsigned REPS      = 5,
  parameter int unsigned FIT_W     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             tone_sel_o,
  input  logic             sample_i,
  input  logic             strobe_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [FIT_W-1:0] fitness_o
);
  localparam int unsigned TOTAL = REPS * WIN_TICKS;
  localparam int unsigned SUM_W = bits_for(TOTAL + 1);

  logic             go, run, fin, div_busy;
  tone_e            tone;
  logic [SUM_W-1:0] sum_lo, sum_hi;

  assign busy_o = run | fin | div_busy;
  assign go     = start_i & ~busy_o;

  tfe_window_seq #(.WIN_TICKS(WIN_TICKS), .REPS(REPS)) u_seq (
    .clk_i, .rst_ni, .go_i(go), .strobe_i, .run_o(run), .tone_o(tone), .fin_o(fin)
  );

  tfe_ones_accum #(.SUM_W(SUM_W)) u_acc (
    .clk_i, .rst_ni, .clr_i(go), .en_i(run & strobe_i), .sample_i,
    .tone_i(tone), .lo_o(sum_lo), .hi_o(sum_hi)
  );

  tfe_fit_div #(.SUM_W(SUM_W), .FIT_W(FIT_W), .TOTAL(TOTAL)) u_div (
    .clk_i, .rst_ni, .go_i(fin), .a_i(sum_lo), .b_i(sum_hi),
    .fit_o(fitness_o), .done_o, .busy_o(div_busy)
  );

  assign tone_sel_o = tone;

  AST_IDLE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !tone_sel_o)); // R2
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && run) |=> $stable(sum_lo) || $past(strobe_i)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R6
endmodule

// File: tb/sim_tone_fitness_eval.sv
module sim_tone_fitness_eval;
  localparam int WIN   = 20;
  localparam int REPS  = 5;
  localparam int FIT_W = 12;
  localparam int TOTAL = WIN * REPS;
  localparam int QB    = FIT_W + 1;
  localparam int FMAX  = (1 << FIT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, sample = 1'b0, strobe = 1'b0;
  logic tone_sel, busy, done;
  logic [FIT_W-1:0] fitness;

  always #4 clk = ~clk;

  tone_fitness_eval #(.WIN_TICKS(WIN), .REPS(REPS), .FIT_W(FIT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tone_sel_o(tone_sel),
    .sample_i(sample), .strobe_i(strobe), .busy_o(busy), .done_o(done),
    .fitness_o(fitness)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  // model state
  int  m_run = 0, m_tick = 0, m_win = 0, m_fin = 0, m_divn = 0;
  int  m_lo = 0, m_hi = 0, m_fit = 0, m_done = 0;
  int  mode = 0, phase = 0;
  bit  start_req = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic int exp_fit(input int a, input int b);
    int d, q;
    d = (a > b) ? a - b : b - a;
    q = (d * (1 << FIT_W)) / TOTAL;
    return (q > FMAX) ? FMAX : q;
  endfunction

  // response pattern per test: tn = tone, tk = tick index inside window
  function automatic bit pat(input int md, input int tn, input int tk, input bit stb);
    case (md)
      1: return stb && tn == 0;
      2: return stb && tn == 1;
      3: return stb;
      4: return stb && ((tn == 0) ? (tk % 2 == 0) : (tk % 4 == 0));
      5: return (tn == 0) ? !stb : (stb && tk < 3);
      6: return stb && ((tn == 1) ? (tk % 2 == 0) : (tk < 7));
      default: return 1'b0;
    endcase
  endfunction

  // called at negedge: compare, drive, then advance model over the next edge
  task automatic step();
    int busy_m;
    bit st, sb, sm, go;
    busy_m = (m_run || m_fin || m_divn != 0);
    chk(busy == busy_m, "R2/R6 busy", busy, busy_m);
    chk(done == m_done, "R6 done", done, m_done);
    chk(tone_sel == m_win[0], "R3 tone_sel", tone_sel, m_win[0]);
    chk(fitness == m_fit, "R5/R8 fitness", fitness, m_fit);
    st = start_req; start_req = 0;
    sb = (phase == 2); phase = (phase + 1) % 3;
    sm = pat(mode, m_win % 2, m_tick, sb);
    start = st; strobe = sb; sample = sm;
    go = st && !busy_m;
    m_done = 0;
    if (m_divn != 0) begin
      m_divn--;
      if (m_divn == 0) begin m_done = 1; m_fit = exp_fit(m_lo, m_hi); end
    end
    if (m_fin) begin m_fin = 0; m_divn = QB; end
    if (go) begin m_lo = 0; m_hi = 0; end
    else if (m_run && sb && sm) begin
      if (m_win % 2 == 0) m_lo++; else m_hi++;
    end
    if (go) begin m_run = 1; m_tick = 0; m_win = 0; end
    else if (m_run && sb) begin
      if (m_tick == WIN - 1) begin
        m_tick = 0;
        if (m_win == 2 * REPS - 1) begin m_run = 0; m_fin = 1; end
        else m_win++;
      end else m_tick++;
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cyc++; step();
    end
  endtask

  task automatic run_test(input int md, input int expv, input string req, input bit poke);
    int guard = 0;
    mode = md;
    start_req = 1;
    cycles(3);
    if (poke) begin
      cycles(50); start_req = 1;   // mid-run start, R7
      cycles(200); start_req = 1;
    end
    while (!done && guard < 5000) begin cycles(1); guard++; end
    chk(done == 1'b1, {req, " done seen"}, done, 1);
    chk(fitness == expv, req, fitness, expv);
    cycles(20);
    chk(fitness == expv, "R8 fitness held", fitness, expv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && tone_sel == 0 && fitness == 0, "R1 reset state",
        {busy, done, tone_sel}, 0);
    rst_n = 1'b1;
    cycles(5);
    run_test(1, FMAX, "R5 clamp low tone all ones", 0);
    run_test(2, FMAX, "R5 R9 high tone all ones", 0);
    run_test(3, 0, "R5 R9 equal sums", 0);
    run_test(4, 1024, "R4 R5 density pattern", 0);
    run_test(5, 614, "R4 off-strobe samples ignored", 0);
    run_test(6, 614, "R7 start while busy ignored", 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule